// File: doc/BRIEF.md
# Framed Serial Configuration Port for a Line-Memory Controller

This block is the serial slave through which a microcontroller programs a dual-bank video line memory. The link has four wires: an active-low select, a serial clock, data in and data out. All four are sampled in the system clock domain. Each transaction opens with a command byte. That byte asks for one of three things: loading a new configuration, reading back the live address and blanking counters, or reading a two-flag status byte.

A configuration load is always a complete seven-byte frame. The five payload bytes carry the read start address and its count direction, the write start address and the horizontal blanking precount. A stop byte follows them, holding a fixed code and an even-parity bit. A frame that passes the check is moved into a shadow copy. A pending flag is then raised, and the shadow reaches the live outputs only on the next rising edge of the vertical sync input. The memory controller therefore never sees a configuration change in the middle of a field. A frame that fails the check is dropped and an error flag is raised.

Top module: `linemem_sio`

## Requirements
- R1: While `cs_ni` is low, one bit is taken from `sdi_i` on each rising edge of `sck_i`, most significant bit first. Raising `cs_ni` restarts byte framing at the command byte.
- R2: The command byte 0x04 starts a configuration write, 0x08 starts a counter readback and 0xF8 starts a status read. Any other value, including RE=WE=1 (0x0C) and 0xF4, starts nothing. Such a transaction drives no output and changes no state.
- R3: Write payload byte 1 holds the count-down flag in bit 7 and read start bits 9:8 in bits 1:0. Byte 2 holds read start bits 7:0. Byte 3 holds write start bits 9:8 in bits 1:0. Byte 4 holds write start bits 7:0. Byte 5 holds the precount. The other bits of bytes 1 and 3 are ignored.
- R4: Stop byte bits 7:1 must equal 1011010b, and bit 0 must make the XOR of all five payload bytes and that bit equal to zero. If both hold, the error flag clears and the pending flag sets. If either fails, the error flag sets and the frame is discarded.
- R5: The configuration outputs change only on the first clock after a rising edge of `vsync_i`, and only while the pending flag is set. That commit clears the pending flag. A sync edge with nothing pending changes nothing.
- R6: A write whose select rises before the 56th serial clock leaves the configuration outputs and both flags unchanged.
- R7: A valid write that arrives while a load is still pending replaces the pending data, and the later frame is the one committed.
- R8: A readback returns five bytes after the command: {000000b, read counter[9:8]}, read counter[7:0], {000000b, write counter[9:8]}, write counter[7:0], and the HD counter. The values are captured when the command byte completes, and the up/down bit is returned as 0.
- R9: A status read returns one byte after the command, with the error flag in bit 7, the pending flag in bit 6 and zeros in the other bits.
- R10: `sdo_oe_o` is high only during the payload bytes of a readback or status read while `cs_ni` is low.
- R11: Reset clears the configuration outputs, both flags, the shadow copy and the current command, and leaves `sdo_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from the controller |
| sdo_o | output | 1 | Serial data to the controller |
| sdo_oe_o | output | 1 | Output enable for the sdo pad (low means high impedance) |
| vsync_i | input | 1 | Vertical sync; its rising edge commits pending data |
| rd_cnt_i | input | ADDR_W | Live read address counter, for readback |
| wr_cnt_i | input | ADDR_W | Live write address counter, for readback |
| hd_cnt_i | input | HD_W | Live HD precounter, for readback |
| rd_start_o | output | ADDR_W | Committed read start address |
| rd_down_o | output | 1 | Committed read count direction (1 = down) |
| wr_start_o | output | ADDR_W | Committed write start address |
| hd_pre_o | output | HD_W | Committed HD precount |

## Verification
A readback or status bit is driven one system clock after the serial clock edge that ends the previous bit. The bench holds each serial clock phase for six system clocks and samples `sdo_o` just before the next rising edge, so every sample falls long after the bit has settled. Committed values appear one clock after the clock that first sees `vsync_i` high. The bench therefore holds sync high for three clocks before it compares the outputs, and it also compares them before the sync edge to prove the load was deferred. Flag changes are observed through a status read issued after the write transaction ends.

// File: rtl/linemem_sio_pkg.sv
package linemem_sio_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_READ, OP_STAT} sio_op_e;

  localparam logic [7:0] CMD_WRITE = 8'h04;
  localparam logic [7:0] CMD_READ  = 8'h08;
  localparam logic [7:0] CMD_STAT  = 8'hF8;
  localparam logic [6:0] STOP_CODE = 7'b1011010;

  localparam int FRAME_BYTES   = 7;
  localparam int PAYLOAD_BYTES = 5;
  localparam int READ_BYTES    = 5;
  localparam int STAT_BYTES    = 1;

  function automatic sio_op_e decode_cmd(input logic [7:0] cmd);
    case (cmd)
      CMD_WRITE: return OP_WRITE;
      CMD_READ:  return OP_READ;
      CMD_STAT:  return OP_STAT;
      default:   return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/linemem_sio_rx.sv
module linemem_sio_rx #(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             sdi_i,
  output logic             sck_rise_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             sck_q;
  logic [2:0]       bit_q;
  logic [IDX_W-1:0] idx_q;
  logic [6:0]       sh_q;

  assign sck_rise_o = sck_i & ~sck_q & ~cs_ni;
  assign byte_vld_o = sck_rise_o & (bit_q == 3'd7);
  assign byte_o     = {sh_q, sdi_i};
  assign idx_o      = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      bit_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else begin
      sck_q <= sck_i;
      if (cs_ni) begin
        bit_q <= '0;
        idx_q <= '0;
      end else if (sck_rise_o) begin
        sh_q  <= {sh_q[5:0], sdi_i};
        bit_q <= bit_q + 3'd1;
        // byte index saturates so long transactions cannot wrap back to the command slot
        if (bit_q == 3'd7 && idx_q != '1) idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/linemem_sio_frame.sv
module linemem_sio_frame
  import linemem_sio_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int HD_W   = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              vsync_i,
  output logic [ADDR_W-1:0] rd_start_o,
  output logic              rd_down_o,
  output logic [ADDR_W-1:0] wr_start_o,
  output logic [HD_W-1:0]   hd_pre_o,
  output logic              pe_o,
  output logic              wf_o
);
  localparam int PAY_W = PAYLOAD_BYTES * 8;
  localparam int HI_W  = ADDR_W - 8;
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(FRAME_BYTES - 1);

  typedef struct packed {
    logic              down;
    logic [ADDR_W-1:0] rd;
    logic [ADDR_W-1:0] wr;
    logic [HD_W-1:0]   hd;
  } cfg_t;

  sio_op_e          op_q;
  logic [PAY_W-1:0] rx_q;
  cfg_t             rx_cfg, shadow_q, live_q;
  logic             pend_q, pe_q, vs_q;
  logic             vs_rise, frame_end, stop_ok;

  always_comb begin
    rx_cfg.down = rx_q[39];
    rx_cfg.rd   = {rx_q[32 +: HI_W], rx_q[31:24]};
    rx_cfg.wr   = {rx_q[16 +: HI_W], rx_q[15:8]};
    rx_cfg.hd   = rx_q[HD_W-1:0];
  end

  assign vs_rise   = vsync_i & ~vs_q;
  assign frame_end = byte_vld_i && (idx_i == STOP_IDX) && (op_q == OP_WRITE);
  assign stop_ok   = (byte_i[7:1] == STOP_CODE) && !(^{rx_q, byte_i[0]});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_NONE;
      rx_q     <= '0;
      shadow_q <= '0;
      live_q   <= '0;
      pend_q   <= 1'b0;
      pe_q     <= 1'b0;
      vs_q     <= 1'b0;
    end else begin
      vs_q <= vsync_i;
      if (vs_rise && pend_q) begin
        live_q <= shadow_q;
        pend_q <= 1'b0;
      end
      if (byte_vld_i) begin
        if (idx_i == '0) op_q <= decode_cmd(byte_i);
        else if (op_q == OP_WRITE && idx_i < STOP_IDX)
          rx_q <= {rx_q[PAY_W-9:0], byte_i};
      end
      // a frame accepted on the sync edge itself stays pending for the next edge
      if (frame_end) begin
        if (stop_ok) begin
          shadow_q <= rx_cfg;
          pend_q   <= 1'b1;
          pe_q     <= 1'b0;
        end else begin
          pe_q <= 1'b1;
        end
      end
    end
  end

  assign rd_down_o  = live_q.down;
  assign rd_start_o = live_q.rd;
  assign wr_start_o = live_q.wr;
  assign hd_pre_o   = live_q.hd;
  assign pe_o       = pe_q;
  assign wf_o       = pend_q;
endmodule

// File: rtl/linemem_sio_tx.sv
module linemem_sio_tx
  import linemem_sio_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int HD_W   = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_rise_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] rd_cnt_i,
  input  logic [ADDR_W-1:0] wr_cnt_i,
  input  logic [HD_W-1:0]   hd_cnt_i,
  input  logic              pe_i,
  input  logic              wf_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int TX_W = READ_BYTES * 8;

  sio_op_e          mode_q;
  logic [TX_W-1:0]  sr_q;
  logic [7:0]       rd_hi, wr_hi, hd_b;
  logic [IDX_W-1:0] last_idx;
  logic             talking;

  always_comb begin
    rd_hi = '0;
    wr_hi = '0;
    hd_b  = '0;
    rd_hi[ADDR_W-9:0] = rd_cnt_i[ADDR_W-1:8];
    wr_hi[ADDR_W-9:0] = wr_cnt_i[ADDR_W-1:8];
    hd_b[HD_W-1:0]    = hd_cnt_i;
  end

  assign last_idx = (mode_q == OP_STAT) ? IDX_W'(STAT_BYTES) : IDX_W'(READ_BYTES);
  assign talking  = (mode_q == OP_READ) || (mode_q == OP_STAT);
  assign sdo_oe_o = talking && !cs_ni && (idx_i != '0) && (idx_i <= last_idx);
  assign sdo_o    = sdo_oe_o & sr_q[TX_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OP_NONE;
      sr_q   <= '0;
    end else if (cs_ni) begin
      mode_q <= OP_NONE;
    end else if (byte_vld_i && idx_i == '0) begin
      // snapshot taken at command end keeps the multi-byte values coherent
      case (decode_cmd(byte_i))
        OP_READ: begin
          mode_q <= OP_READ;
          sr_q   <= {rd_hi, rd_cnt_i[7:0], wr_hi, wr_cnt_i[7:0], hd_b};
        end
        OP_STAT: begin
          mode_q <= OP_STAT;
          sr_q   <= {pe_i, wf_i, {(TX_W-2){1'b0}}};
        end
        default: mode_q <= OP_NONE;
      endcase
    end else if (sck_rise_i && talking) begin
      sr_q <= {sr_q[TX_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/linemem_sio.sv
module linemem_sio #(
  parameter int ADDR_W = 10,
  parameter int HD_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              vsync_i,
  input  logic [ADDR_W-1:0] rd_cnt_i,
  input  logic [ADDR_W-1:0] wr_cnt_i,
  input  logic [HD_W-1:0]   hd_cnt_i,
  output logic [ADDR_W-1:0] rd_start_o,
  output logic              rd_down_o,
  output logic [ADDR_W-1:0] wr_start_o,
  output logic [HD_W-1:0]   hd_pre_o
);
  localparam int IDX_W = 3;

  logic             sck_rise, byte_vld, pe, wf;
  logic [7:0]       rx_byte;
  logic [IDX_W-1:0] byte_idx;

  linemem_sio_rx #(.IDX_W(IDX_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_i      (sck_i),
    .sdi_i      (sdi_i),
    .sck_rise_o (sck_rise),
    .byte_vld_o (byte_vld),
    .byte_o     (rx_byte),
    .idx_o      (byte_idx)
  );

  linemem_sio_frame #(.ADDR_W(ADDR_W), .HD_W(HD_W), .IDX_W(IDX_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld),
    .byte_i     (rx_byte),
    .idx_i      (byte_idx),
    .vsync_i    (vsync_i),
    .rd_start_o (rd_start_o),
    .rd_down_o  (rd_down_o),
    .wr_start_o (wr_start_o),
    .hd_pre_o   (hd_pre_o),
    .pe_o       (pe),
    .wf_o       (wf)
  );

  linemem_sio_tx #(.ADDR_W(ADDR_W), .HD_W(HD_W), .IDX_W(IDX_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_rise_i (sck_rise),
    .byte_vld_i (byte_vld),
    .byte_i     (rx_byte),
    .idx_i      (byte_idx),
    .rd_cnt_i   (rd_cnt_i),
    .wr_cnt_i   (wr_cnt_i),
    .hd_cnt_i   (hd_cnt_i),
    .pe_i       (pe),
    .wf_i       (wf),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o)
  );
endmodule

// File: rtl/linemem_sio_chk.sv
module linemem_sio_chk #(
  parameter int ADDR_W = 10,
  parameter int HD_W   = 8,
  parameter int IDX_W  = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       vsync_i,
  input logic                       sdo_oe_o,
  input logic [2*ADDR_W+HD_W:0]     cfg_i,
  input logic                       byte_vld_i,
  input logic [IDX_W-1:0]           idx_i,
  input logic                       pe_i,
  input logic                       wf_i
);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(6);

  AST_OE_STARTS_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(byte_vld_i && idx_i == '0)); // R10

  AST_CFG_MOVES_ON_VSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_i) |-> ($past(vsync_i) && !$past(vsync_i, 2))); // R5

  AST_WF_CLEARS_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wf_i && vsync_i && !$past(vsync_i)) |=> (!wf_i || $past(byte_vld_i))); // R5

  AST_PE_SETS_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pe_i) |-> $past(byte_vld_i && idx_i == STOP_IDX)); // R4

  AST_WF_SETS_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wf_i) |-> $past(byte_vld_i && idx_i == STOP_IDX)); // R4
endmodule

bind linemem_sio linemem_sio_chk #(.ADDR_W(ADDR_W), .HD_W(HD_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vsync_i    (vsync_i),
  .sdo_oe_o   (sdo_oe_o),
  .cfg_i      ({rd_down_o, rd_start_o, wr_start_o, hd_pre_o}),
  .byte_vld_i (byte_vld),
  .idx_i      (byte_idx),
  .pe_i       (pe),
  .wf_i       (wf)
);

// File: tb/sim_linemem_sio.sv
module sim_linemem_sio;
  localparam int ADDR_W = 10;
  localparam int HD_W   = 8;
  localparam int HALF   = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, sdi = 1'b0, vsync = 1'b0;
  logic sdo, sdo_oe;
  logic [ADDR_W-1:0] rd_cnt = '0, wr_cnt = '0, rd_start, wr_start;
  logic [HD_W-1:0]   hd_cnt = '0, hd_pre;
  logic              rd_down;

  always #2 clk = ~clk;

  linemem_sio #(.ADDR_W(ADDR_W), .HD_W(HD_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .vsync_i(vsync),
    .rd_cnt_i(rd_cnt), .wr_cnt_i(wr_cnt), .hd_cnt_i(hd_cnt),
    .rd_start_o(rd_start), .rd_down_o(rd_down), .wr_start_o(wr_start), .hd_pre_o(hd_pre)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] txb [0:6];
  logic [7:0] rxb [0:6];
  logic [7:0] rxoe [0:6];
  int chg_bit = -1;
  logic [28:0] e_live = '0, e_sh = '0;
  logic e_pe = 0, e_wf = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [28:0] cfg_now();
    return {rd_down, rd_start, wr_start, hd_pre};
  endfunction

  task automatic xfer(input int nbits);
    for (int b = 0; b < 7; b++) begin rxb[b] = '0; rxoe[b] = '0; end
    cs_ni = 1'b0;
    wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      sdi = txb[i/8][7-(i%8)];
      if (i == chg_bit) begin
        rd_cnt = ADDR_W'($urandom);
        wr_cnt = ADDR_W'($urandom);
        hd_cnt = HD_W'($urandom);
      end
      wclk(HALF);
      rxb[i/8][7-(i%8)]  = sdo;
      rxoe[i/8][7-(i%8)] = sdo_oe;
      sck = 1'b1;
      wclk(HALF);
    end
    sck = 1'b0;
    wclk(HALF);
    cs_ni = 1'b1;
    wclk(HALF);
    chg_bit = -1;
  endtask

  // mode 0 clean, 1 parity flipped, 2 stop code damaged
  task automatic mk_write(input logic [28:0] c, input int mode);
    logic par;
    txb[0] = 8'h04;
    txb[1] = {c[28], 5'($urandom), c[27:26]};
    txb[2] = c[25:18];
    txb[3] = {6'($urandom), c[17:16]};
    txb[4] = c[15:8];
    txb[5] = c[7:0];
    par = ^{txb[1], txb[2], txb[3], txb[4], txb[5]};
    txb[6] = {7'b1011010, par};
    if (mode == 1) txb[6][0] = ~txb[6][0];
    if (mode == 2) txb[6][7:1] = txb[6][7:1] ^ (7'd1 << ($urandom % 7));
  endtask

  task automatic do_write(input logic [28:0] c, input int mode, input int nbits);
    mk_write(c, mode);
    xfer(nbits);
    if (nbits >= 56) begin
      if (mode == 0) begin e_sh = c; e_wf = 1; e_pe = 0; end
      else e_pe = 1;
    end
    chk(cfg_now() == e_live, "R5 load deferred until sync", 64'(cfg_now()), 64'(e_live));
    chk(sdo_oe == 1'b0, "R10 no drive during write", 64'(sdo_oe), 0);
  endtask

  task automatic stat_chk(input string req);
    txb[0] = 8'hF8;
    txb[1] = 8'($urandom);
    xfer(16);
    chk(rxb[1] == {e_pe, e_wf, 6'b0}, req, 64'(rxb[1]), 64'({e_pe, e_wf, 6'b0}));
    chk(rxoe[0] == 8'h00 && rxoe[1] == 8'hFF, "R10 status drive window", 64'({rxoe[0], rxoe[1]}), 64'h00FF);
    chk(sdo_oe == 1'b0, "R10 released after select high", 64'(sdo_oe), 0);
  endtask

  task automatic sync_chk(input string req);
    vsync = 1'b1;
    wclk(3);
    if (e_wf) begin e_live = e_sh; e_wf = 0; end
    chk(cfg_now() == e_live, req, 64'(cfg_now()), 64'(e_live));
    vsync = 1'b0;
    wclk(3);
  endtask

  task automatic read_chk();
    logic [ADDR_W-1:0] r, w;
    logic [HD_W-1:0] h;
    logic [39:0] got, exp;
    rd_cnt = ADDR_W'($urandom); wr_cnt = ADDR_W'($urandom); hd_cnt = HD_W'($urandom);
    r = rd_cnt; w = wr_cnt; h = hd_cnt;
    txb[0] = 8'h08;
    for (int b = 1; b < 7; b++) txb[b] = 8'($urandom);
    chg_bit = 20;
    xfer(48);
    got = {rxb[1], rxb[2], rxb[3], rxb[4], rxb[5]};
    exp = {6'b0, r[9:8], r[7:0], 6'b0, w[9:8], w[7:0], h};
    chk(got == exp, "R8 R1 readback bytes snapshot", 64'(got), 64'(exp));
    chk(rxoe[0] == 8'h00 && {rxoe[1], rxoe[2], rxoe[3], rxoe[4], rxoe[5]} == 40'hFF_FFFF_FFFF,
        "R10 readback drive window", 64'({rxoe[0], rxoe[5]}), 64'h00FF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [28:0] a, b;
    void'($urandom(32'h5eed_7308));
    wclk(4);
    rst_ni = 1'b1;
    wclk(2);
    chk(cfg_now() == '0, "R11 reset config", 64'(cfg_now()), 0);
    chk(sdo_oe == 1'b0, "R11 reset output released", 64'(sdo_oe), 0);
    stat_chk("R11 R9 status after reset");
    read_chk();

    a = {1'b1, 10'h2A5, 10'h13C, 8'h9E};
    do_write(a, 0, 56);
    stat_chk("R4 R9 valid frame pending");
    sync_chk("R3 R5 commit on sync edge");
    stat_chk("R5 pending cleared by commit");
    sync_chk("R5 sync without pending");

    do_write({1'b0, 10'h001, 10'h3FF, 8'h00}, 1, 56);
    stat_chk("R4 parity error flagged");
    sync_chk("R4 bad parity not committed");
    do_write({1'b1, 10'h155, 10'h0AA, 8'h7F}, 2, 56);
    stat_chk("R4 stop code error flagged");
    sync_chk("R4 bad stop not committed");
    do_write({1'b0, 10'h3FF, 10'h000, 8'hFF}, 0, 56);
    stat_chk("R4 valid frame clears error");
    sync_chk("R3 R5 commit after error");

    do_write({1'b1, 10'h0F0, 10'h30F, 8'h55}, 0, 40);
    stat_chk("R6 aborted frame leaves flags");
    sync_chk("R6 aborted frame not committed");

    a = {1'b1, 10'h111, 10'h222, 8'h33};
    b = {1'b0, 10'h2DD, 10'h0EE, 8'hC4};
    do_write(a, 0, 56);
    do_write(b, 0, 56);
    stat_chk("R7 pending after second write");
    sync_chk("R7 later frame committed");

    foreach (txb[i]) txb[i] = 8'h00;
    mk_write({1'b1, 10'h3A3, 10'h1B1, 8'h42}, 0);
    txb[0] = 8'h0C;
    xfer(56);
    chk(rxoe[1] == 0 && rxoe[3] == 0 && rxoe[6] == 0, "R2 prohibited command silent", 64'(rxoe[1]), 0);
    stat_chk("R2 prohibited command no flags");
    txb[0] = 8'hF4;
    xfer(56);
    chk(rxoe[1] == 0 && rxoe[5] == 0, "R2 status group with write silent", 64'(rxoe[1]), 0);
    txb[0] = 8'h05;
    xfer(56);
    stat_chk("R2 odd command no flags");
    sync_chk("R2 ignored commands not committed");

    for (int it = 0; it < 40; it++) begin
      int m;
      m = $urandom % 4;
      a = 29'($urandom);
      if (m == 3) do_write(a, 0, 8 + ($urandom % 48));
      else do_write(a, m, 56);
      if ($urandom % 2) stat_chk("R4 R9 random status");
      if ($urandom % 3 == 0) read_chk();
      if ($urandom % 2) sync_chk("R5 R7 random commit");
    end
    sync_chk("R5 final commit");
    finish_run();
  end
endmodule